// File: doc/BRIEF.md
# Transceiver Reset Sequencer

This block brings one serial transceiver (a transmit channel plus a receive channel whose clock-data-recovery loop is steered by hand) out of power-down in a safe order. It first keeps the transmit PLL powered down for a minimum time. It then releases the transmit logic once that PLL reports lock. Once the reconfiguration logic has gone quiet, it lets the receiver's analog front end run while the recovery loop trains on the reference clock. After the receive PLL has held lock for a long dwell, it hands the loop over to the incoming data. A second, shorter dwell follows before the receiver's digital logic leaves reset.

Every interval is given in nanoseconds together with the clock rate in kHz. Each is converted to a whole number of clock cycles, rounded up, so that no interval is ever shorter than asked. All three status inputs are asynchronous to the clock and pass through a synchronizer before the sequencer acts on them. The block has no data path. Every pin is a plain level control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are: power-down 1, all three resets 1, reference select 1, data select 0, done 0.
- R2: After reset release, `pll_pdn_o` stays high for at least ceil(PDN_NS·CLK_KHZ/10^6) cycles (50 at defaults). While it is high, all three resets and reference select are high and data select is low.
- R3: `tx_dig_rst_o` falls only after `tx_pll_lock_i` is high. It falls within 5 cycles of that input rising once power-down has ended.
- R4: `rx_ana_rst_o` falls only after the transmit reset has been released and `reconf_busy_i` has been low for at least BUSY_QUIET_CYC (2) consecutive synchronized cycles.
- R5: Exactly one of `cdr_ref_sel_o` and `cdr_data_sel_o` is high at any time. Reference select stays high after the analog reset is released, until the reference dwell ends.
- R6: `cdr_data_sel_o` rises no sooner than ceil(REF_DWELL_NS·CLK_KHZ/10^6) cycles (750 at defaults) after `rx_pll_lock_i` rises. If receive lock drops during the dwell, the dwell restarts from the next rise.
- R7: `rx_dig_rst_o` falls no sooner than ceil(DATA_DWELL_NS·CLK_KHZ/10^6) cycles (200 at defaults) after data select rises, and no more than 3 cycles later.
- R8: If `tx_pll_lock_i` drops at any point after the transmit reset has been released, the block returns to power-down. It re-asserts every reset and reference select and runs the full power-down interval again.
- R9: `seq_done_o` is high only when power-down and all resets are released and data select is high.
- R10: A busy low pulse shorter than BUSY_QUIET_CYC cycles does not release the receiver analog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_pll_lock_i | input | 1 | Transmit PLL lock status (asynchronous) |
| rx_pll_lock_i | input | 1 | Receive PLL lock status (asynchronous) |
| reconf_busy_i | input | 1 | Reconfiguration logic busy (asynchronous) |
| pll_pdn_o | output | 1 | Transmit PLL power-down |
| tx_dig_rst_o | output | 1 | Transmit digital reset |
| rx_ana_rst_o | output | 1 | Receiver analog reset |
| rx_dig_rst_o | output | 1 | Receiver digital reset |
| cdr_ref_sel_o | output | 1 | Recovery loop tracks the reference clock |
| cdr_data_sel_o | output | 1 | Recovery loop tracks incoming data |
| seq_done_o | output | 1 | Sequence complete, channel live |

## Verification
The hardest situation to reach from the ports is a receive-lock drop in the middle of the 750-cycle reference dwell. The bench reaches it by walking the whole bring-up first, then holding receive lock for 400 cycles before removing it. It then checks that the hand-over has not happened and times the restarted dwell from the new rising edge. Two more cases need careful timing. A one-cycle quiet gap in busy is driven right after the transmit reset releases. A transmit-lock loss is applied only after done is high, and the bench re-times the repeated power-down interval.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

  typedef enum logic [2:0] {
    ST_PDN      = 3'd0,
    ST_WAIT_TX  = 3'd1,
    ST_QUIET    = 3'd2,
    ST_REF_TRN  = 3'd3,
    ST_REF_DWL  = 3'd4,
    ST_DATA_DWL = 3'd5,
    ST_LIVE     = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic pdn;
    logic tx_rst;
    logic ana_rst;
    logic dig_rst;
    logic ref_sel;
    logic data_sel;
    logic done;
  } ctl_t;

  // Output levels belonging to each state.
  function automatic ctl_t ctl_of(seq_state_e s);
    ctl_t c;
    c = '{pdn: 1'b0, tx_rst: 1'b1, ana_rst: 1'b1, dig_rst: 1'b1,
          ref_sel: 1'b1, data_sel: 1'b0, done: 1'b0};
    case (s)
      ST_PDN:      c.pdn = 1'b1;
      ST_WAIT_TX:  ;
      ST_QUIET:    c.tx_rst = 1'b0;
      ST_REF_TRN,
      ST_REF_DWL: begin
        c.tx_rst  = 1'b0;
        c.ana_rst = 1'b0;
      end
      ST_DATA_DWL: begin
        c.tx_rst   = 1'b0;
        c.ana_rst  = 1'b0;
        c.ref_sel  = 1'b0;
        c.data_sel = 1'b1;
      end
      ST_LIVE: begin
        c.tx_rst   = 1'b0;
        c.ana_rst  = 1'b0;
        c.dig_rst  = 1'b0;
        c.ref_sel  = 1'b0;
        c.data_sel = 1'b1;
        c.done     = 1'b1;
      end
      default: c.pdn = 1'b1;
    endcase
    return c;
  endfunction

  // Nanoseconds to cycles, rounded up, never below one.
  function automatic longint ns_to_cyc(longint ns, longint khz);
    longint c;
    c = (ns * khz + 64'd999_999) / 64'd1_000_000;
    return (c < 1) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
  parameter int CNT_W = 10,
  parameter int MAX   = 750
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] tgt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr)           cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  // tgt counts elapsed cycles including the current one
  assign expire = (cnt_q >= (tgt - 1'b1));

  // R2: counter never runs past the largest interval
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CMAX);

  // R6: clearing always restarts the interval from zero
  assert_clr_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int CLK_KHZ        = 50_000,
  parameter int PDN_NS         = 1_000,
  parameter int REF_DWELL_NS   = 15_000,
  parameter int DATA_DWELL_NS  = 4_000,
  parameter int BUSY_QUIET_CYC = 2,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_pll_lock_i,
  input  logic rx_pll_lock_i,
  input  logic reconf_busy_i,
  output logic pll_pdn_o,
  output logic tx_dig_rst_o,
  output logic rx_ana_rst_o,
  output logic rx_dig_rst_o,
  output logic cdr_ref_sel_o,
  output logic cdr_data_sel_o,
  output logic seq_done_o
);
  import xrs_pkg::*;

  localparam int PDN_CYC  = int'(ns_to_cyc(longint'(PDN_NS), longint'(CLK_KHZ)));
  localparam int REF_CYC  = int'(ns_to_cyc(longint'(REF_DWELL_NS), longint'(CLK_KHZ)));
  localparam int DATA_CYC = int'(ns_to_cyc(longint'(DATA_DWELL_NS), longint'(CLK_KHZ)));
  localparam int BUSY_CYC = (BUSY_QUIET_CYC < 1) ? 1 : BUSY_QUIET_CYC;
  localparam int MAX_A    = (PDN_CYC > REF_CYC) ? PDN_CYC : REF_CYC;
  localparam int MAX_B    = (DATA_CYC > BUSY_CYC) ? DATA_CYC : BUSY_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  // synchronized status
  logic [2:0] st_raw, st_s;
  logic       tx_s, rx_s, busy_s;

  assign st_raw = {reconf_busy_i, rx_pll_lock_i, tx_pll_lock_i};

  xrs_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(st_raw), .q(st_s)
  );

  assign tx_s   = st_s[0];
  assign rx_s   = st_s[1];
  assign busy_s = st_s[2];

  seq_state_e       state_q, state_d;
  logic             tmr_clr, tmr_exp;
  logic [CNT_W-1:0] tmr_tgt;
  ctl_t             ctl_q;

  always_comb begin
    state_d = state_q;
    tmr_tgt = CNT_W'(1);
    case (state_q)
      ST_PDN: begin
        tmr_tgt = CNT_W'(PDN_CYC);
        if (tmr_exp) state_d = ST_WAIT_TX;
      end
      ST_WAIT_TX: begin
        if (tx_s) state_d = ST_QUIET;
      end
      ST_QUIET: begin
        tmr_tgt = CNT_W'(BUSY_CYC);
        if (!tx_s)                  state_d = ST_PDN;
        else if (!busy_s && tmr_exp) state_d = ST_REF_TRN;
      end
      ST_REF_TRN: begin
        if (!tx_s)     state_d = ST_PDN;
        else if (rx_s) state_d = ST_REF_DWL;
      end
      ST_REF_DWL: begin
        tmr_tgt = CNT_W'(REF_CYC);
        if (!tx_s)        state_d = ST_PDN;
        else if (!rx_s)   state_d = ST_REF_TRN;
        else if (tmr_exp) state_d = ST_DATA_DWL;
      end
      ST_DATA_DWL: begin
        tmr_tgt = CNT_W'(DATA_CYC);
        if (!tx_s)        state_d = ST_PDN;
        else if (tmr_exp) state_d = ST_LIVE;
      end
      ST_LIVE: begin
        if (!tx_s) state_d = ST_PDN;
      end
      default: state_d = ST_PDN;
    endcase
  end

  // restart the timer on every state change, and while busy is seen
  assign tmr_clr = (state_d != state_q) || ((state_q == ST_QUIET) && busy_s);

  xrs_timer #(.CNT_W(CNT_W), .MAX(MAX_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tgt(tmr_tgt), .expire(tmr_exp)
  );

  // outputs registered alongside the state, no decode glitches
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PDN;
      ctl_q   <= ctl_of(ST_PDN);
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_of(state_d);
    end
  end

  assign pll_pdn_o      = ctl_q.pdn;
  assign tx_dig_rst_o   = ctl_q.tx_rst;
  assign rx_ana_rst_o   = ctl_q.ana_rst;
  assign rx_dig_rst_o   = ctl_q.dig_rst;
  assign cdr_ref_sel_o  = ctl_q.ref_sel;
  assign cdr_data_sel_o = ctl_q.data_sel;
  assign seq_done_o     = ctl_q.done;

  // R2: power-down implies everything else held
  assert_pdn_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pdn_o |-> (tx_dig_rst_o && rx_ana_rst_o && rx_dig_rst_o &&
                   cdr_ref_sel_o && !cdr_data_sel_o));

  // R3: transmit reset leaves only on a synchronized lock
  assert_tx_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_dig_rst_o) |-> $past(tx_s));

  // R4: analog release after transmit release and a quiet busy
  assert_ana_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ana_rst_o) |-> (!tx_dig_rst_o && $past(!busy_s)));

  // R5: exactly one loop mode selected
  assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cdr_ref_sel_o, cdr_data_sel_o}) == 1);

  // R6: hand-over to data only while receive lock is held
  assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cdr_data_sel_o) |-> $past(rx_s));

  // R7: receiver digital reset released only in data mode
  assert_dig_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_dig_rst_o) |-> $past(cdr_data_sel_o));

  // R8: losing transmit lock while running forces power-down
  assert_lockloss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_s && !tx_dig_rst_o) |=> pll_pdn_o);

  // R9: done only with all controls released in data mode
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_o |-> (!pll_pdn_o && !tx_dig_rst_o && !rx_ana_rst_o &&
                    !rx_dig_rst_o && cdr_data_sel_o));
endmodule

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_lock = 1'b0, rx_lock = 1'b0, busy = 1'b1;
  logic pdn, txr, anar, digr, refs, datas, done;
  int   n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  xcvr_rst_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_pll_lock_i(tx_lock), .rx_pll_lock_i(rx_lock), .reconf_busy_i(busy),
    .pll_pdn_o(pdn), .tx_dig_rst_o(txr), .rx_ana_rst_o(anar),
    .rx_dig_rst_o(digr), .cdr_ref_sel_o(refs), .cdr_data_sel_o(datas),
    .seq_done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(input int idx);
    case (idx)
      0: return pdn;
      1: return txr;
      2: return anar;
      3: return digr;
      4: return refs;
      5: return datas;
      default: return done;
    endcase
  endfunction

  task automatic wait_sig(input int idx, input logic val, input int maxc,
                          output int n);
    n = 0;
    while (sig(idx) !== val && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tx_lock = 1'b0; rx_lock = 1'b0; busy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // up to reference training with the analog reset released
  task automatic bring_to_ref();
    int n;
    do_reset();
    wait_sig(0, 1'b0, 200, n);
    tx_lock = 1'b1;
    wait_sig(1, 1'b0, 20, n);
    busy = 1'b0;
    wait_sig(2, 1'b0, 20, n);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check({pdn, txr, anar, digr, refs, datas, done} == 7'b1111100, "R1",
          "outputs in reset", int'({pdn, txr, anar, digr, refs, datas, done}),
          int'(7'b1111100));
  endtask

  task automatic t_bringup();
    int n;
    do_reset();
    wait_sig(0, 1'b0, 200, n);
    check(n >= 50 && n <= 52, "R2", "power-down cycles", n, 50);
    repeat (10) @(negedge clk);
    check(txr == 1'b1, "R3", "tx reset without lock", int'(txr), 1);
    tx_lock = 1'b1;
    wait_sig(1, 1'b0, 20, n);
    check(n >= 2 && n <= 5, "R3", "tx release latency", n, 3);
    repeat (20) @(negedge clk);
    check(anar == 1'b1, "R4", "analog reset while busy", int'(anar), 1);
    busy = 1'b0;
    wait_sig(2, 1'b0, 20, n);
    check(n >= 2 && n <= 7, "R4", "quiet-busy latency", n, 4);
    check(refs == 1'b1 && datas == 1'b0, "R5", "ref mode after analog release",
          int'({refs, datas}), 2);
    repeat (30) @(negedge clk);
    check(refs == 1'b1 && digr == 1'b1, "R5", "ref mode held without rx lock",
          int'({refs, digr}), 3);
    rx_lock = 1'b1;
    wait_sig(5, 1'b0 ^ 1'b1, 1000, n);
    check(n >= 750 && n <= 760, "R6", "reference dwell", n, 753);
    check(refs == 1'b0, "R5", "ref select dropped at hand-over", int'(refs), 0);
    check(done == 1'b0, "R9", "not done during data dwell", int'(done), 0);
    wait_sig(3, 1'b0, 400, n);
    check(n >= 200 && n <= 203, "R7", "data dwell", n, 200);
    check(done == 1'b1 && !pdn && !txr && !anar && datas, "R9", "done when live",
          int'(done), 1);
  endtask

  task automatic t_busy_glitch();
    int n;
    do_reset();
    wait_sig(0, 1'b0, 200, n);
    tx_lock = 1'b1;
    wait_sig(1, 1'b0, 20, n);
    repeat (4) @(negedge clk);
    busy = 1'b0;
    @(negedge clk);
    busy = 1'b1;
    repeat (15) @(negedge clk);
    check(anar == 1'b1, "R10", "short busy gap ignored", int'(anar), 1);
    busy = 1'b0;
    wait_sig(2, 1'b0, 20, n);
    check(anar == 1'b0, "R4", "release after lasting quiet", int'(anar), 0);
  endtask

  task automatic t_rx_drop();
    int n;
    bring_to_ref();
    rx_lock = 1'b1;
    repeat (400) @(negedge clk);
    rx_lock = 1'b0;
    repeat (10) @(negedge clk);
    check(datas == 1'b0 && refs == 1'b1, "R6", "no hand-over after lock drop",
          int'(datas), 0);
    rx_lock = 1'b1;
    wait_sig(5, 1'b1, 1000, n);
    check(n >= 750 && n <= 760, "R6", "dwell restarted", n, 753);
  endtask

  task automatic t_tx_loss();
    int n;
    bring_to_ref();
    rx_lock = 1'b1;
    wait_sig(6, 1'b1, 1200, n);
    check(done == 1'b1, "R9", "live before loss", int'(done), 1);
    tx_lock = 1'b0;
    wait_sig(0, 1'b1, 10, n);
    check(n <= 5, "R8", "power-down after tx lock loss", n, 4);
    check(txr && anar && digr && refs && !datas && !done, "R8",
          "all resets re-asserted", int'({txr, anar, digr, refs, datas, done}),
          int'(6'b111100));
    wait_sig(0, 1'b0, 200, n);
    check(n >= 49 && n <= 52, "R8", "repeated power-down length", n, 50);
    tx_lock = 1'b1;
    wait_sig(1, 1'b0, 20, n);
    check(txr == 1'b0, "R8", "tx released after relock", int'(txr), 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bringup();
    t_busy_glitch();
    t_rx_drop();
    t_tx_loss();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule